// File: doc/BRIEF.md
# Multi-Mode Reloading Timer/Counter

This block is a down-counter paired with a second register of the same width. Depending on a three-bit mode code, the second register is either the value the counter reloads on underflow or the place where the counter value is captured on an edge of an external pin. The counter advances either on an instruction-cycle tick (timer modes) or on a selected edge of the external pin (event modes). Mode 101 also flips an output pin on every underflow, so a square wave or pulse-width output can be produced by changing the reload value between underflows.

A processor reaches the block through a byte-wide register port. The counter and the reload/capture register each occupy one address per byte, and a control byte holds the mode, a run bit, an interrupt enable and a pending flag. The pending flag records underflows, or capture edges in the capture modes. The interrupt request is the pending flag gated by the enable.

Top module: `mm_timer`

## Requirements
- R1: After reset every readable register is 0, and the toggle output, the pending flag and the interrupt request are low.
- R2: Address 0 and 1 hold the counter low and high byte, 2 and 3 the reload/capture low and high byte, 4 the control byte laid out as mode in bits 7:5, run in bit 4, interrupt enable in bit 1 and pending in bit 0, with other bits reading 0. Other addresses read 0. A write shows on the read port from the next cycle, and a counter byte write takes priority over counting in the same cycle.
- R3: In modes 100, 101, 110 and 111 the counter decrements by one on each tick while run is 1.
- R4: In modes 000, 001, 100 and 101 a decrement from 0 loads the counter from the reload register, so a reload value N gives an underflow period of N+1 counts.
- R5: Mode 000 decrements once per rising edge and mode 001 once per falling edge of the external pin. The pin passes through two synchronizing flops and is sampled only on ticks, so at most one edge counts per tick.
- R6: In mode 101 every underflow inverts the toggle output; in all other cases the toggle output holds its value, including across mode changes.
- R7: Mode 110 copies the counter (its value before that cycle's decrement) into the reload/capture register on a rising pin edge and mode 111 on a falling one; in these modes a decrement from 0 wraps the counter to all ones.
- R8: With run at 0 the counter and the reload/capture register change only by bus writes; no edge is counted or captured.
- R9: Modes 010 and 011 neither count, capture, nor set the pending flag.
- R10: Pending is set by an underflow in modes 000, 001, 100, 101 or by a capture edge in modes 110, 111; the interrupt request is high exactly when pending and the enable are both 1.
- R11: Writing the control byte with bit 0 at 0 clears pending, writing bit 0 at 1 does not set it, and a set event in the same cycle as a clearing write leaves pending at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Instruction-cycle tick, one clock wide |
| pin_in | input | 1 | External timer pin, asynchronous |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| pin_out | output | 1 | Toggle output |
| pend | output | 1 | Pending flag |
| irq | output | 1 | Interrupt request |

## Verification
A register write or a tick-driven decrement, reload, capture or toggle lands on the clock edge where it is presented and is visible one cycle later on the read port, pin_out, pend and irq. A pin change needs two clocks through the synchronizer and is then counted at the first tick after that, so its effect appears one cycle after that tick. The bench model runs this same delay chain at each rising edge and every output is compared at the following falling edge, so each result is checked in exactly the cycle it is due, with directed checks added on hand-computed values at quiet points.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  typedef enum logic [2:0] {
    MD_EVT_RISE = 3'b000,
    MD_EVT_FALL = 3'b001,
    MD_BAD_A    = 3'b010,
    MD_BAD_B    = 3'b011,
    MD_TMR      = 3'b100,
    MD_TMR_TGL  = 3'b101,
    MD_CAP_RISE = 3'b110,
    MD_CAP_FALL = 3'b111
  } tmr_mode_e;

  localparam int CTRL_PEND_BIT = 0;
  localparam int CTRL_IE_BIT   = 1;
  localparam int CTRL_RUN_BIT  = 4;
  localparam int CTRL_MODE_LSB = 5;

endpackage

// File: rtl/tmr_sync_edge.sv
module tmr_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic pin,
  output logic rise,
  output logic fall
);

  logic [STAGES-1:0] sync_q, sync_n;
  logic              smp_q, smp_n;
  logic              lvl;

  assign lvl = sync_q[STAGES-1];

  always_comb begin
    sync_n = {sync_q[STAGES-2:0], pin};
    smp_n  = smp_q;
    if (tick) smp_n = lvl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      smp_q  <= 1'b0;
    end else begin
      sync_q <= sync_n;
      smp_q  <= smp_n;
    end
  end

  assign rise = tick &  lvl & ~smp_q;
  assign fall = tick & ~lvl &  smp_q;

  // R5: an edge seen on a tick cannot be seen again on the next cycle
  assert_no_double_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int CW = 16,
  parameter int BW = 8,
  localparam int NB = CW / BW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dec,
  input  logic          cap,
  input  logic          reload_on_uf,
  input  logic [NB-1:0] cnt_we,
  input  logic [NB-1:0] rld_we,
  input  logic [BW-1:0] wdata,
  output logic [CW-1:0] count,
  output logic [CW-1:0] rld,
  output logic          uf
);

  logic [CW-1:0] cnt_q, cnt_n;
  logic [CW-1:0] rld_q, rld_n;

  assign uf = dec & (cnt_q == '0);

  always_comb begin
    cnt_n = cnt_q;
    if (dec) begin
      if (cnt_q == '0) cnt_n = reload_on_uf ? rld_q : '1;
      else             cnt_n = cnt_q - 1'b1;
    end
    rld_n = rld_q;
    if (cap) rld_n = cnt_q;
    for (int b = 0; b < NB; b++) begin
      if (cnt_we[b]) cnt_n[b*BW +: BW] = wdata;
      if (rld_we[b]) rld_n[b*BW +: BW] = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rld_q <= '0;
    end else begin
      cnt_q <= cnt_n;
      rld_q <= rld_n;
    end
  end

  assign count = cnt_q;
  assign rld   = rld_q;

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!dec && !cap && cnt_we == '0 && rld_we == '0) |=> ($stable(cnt_q) && $stable(rld_q)));

  assert_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (uf && reload_on_uf && cnt_we == '0 && rld_we == '0) |=> (cnt_q == $past(rld_q)));

  assert_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cap && rld_we == '0) |=> (rld_q == $past(cnt_q)));

endmodule

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       rise,
  input  logic       fall,
  input  logic       uf,
  input  logic       ctrl_we,
  input  logic [7:0] wdata,
  output logic [7:0] ctrl_byte,
  output logic       dec,
  output logic       cap,
  output logic       reload_on_uf,
  output logic       pin_out,
  output logic       pend,
  output logic       irq
);

  tmr_mode_e mode_q, mode_n;
  logic      run_q, run_n;
  logic      ie_q, ie_n;
  logic      pend_q, pend_n;
  logic      tgl_q, tgl_n;
  logic      ev, set_p, tog;

  assign ev = mode_q[0] ? fall : rise;

  always_comb begin
    dec          = 1'b0;
    cap          = 1'b0;
    reload_on_uf = 1'b0;
    unique case (mode_q)
      MD_EVT_RISE, MD_EVT_FALL: begin
        dec          = run_q & ev;
        reload_on_uf = 1'b1;
      end
      MD_TMR, MD_TMR_TGL: begin
        dec          = run_q & tick;
        reload_on_uf = 1'b1;
      end
      MD_CAP_RISE, MD_CAP_FALL: begin
        dec = run_q & tick;
        cap = run_q & ev;
      end
      default: ;
    endcase
  end

  assign set_p = (uf & reload_on_uf) | cap;
  assign tog   = uf & (mode_q == MD_TMR_TGL);

  always_comb begin
    mode_n = mode_q;
    run_n  = run_q;
    ie_n   = ie_q;
    pend_n = pend_q;
    tgl_n  = tgl_q ^ tog;
    if (ctrl_we) begin
      mode_n = tmr_mode_e'(wdata[CTRL_MODE_LSB +: 3]);
      run_n  = wdata[CTRL_RUN_BIT];
      ie_n   = wdata[CTRL_IE_BIT];
      if (!wdata[CTRL_PEND_BIT]) pend_n = 1'b0;
    end
    if (set_p) pend_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MD_EVT_RISE;
      run_q  <= 1'b0;
      ie_q   <= 1'b0;
      pend_q <= 1'b0;
      tgl_q  <= 1'b0;
    end else begin
      mode_q <= mode_n;
      run_q  <= run_n;
      ie_q   <= ie_n;
      pend_q <= pend_n;
      tgl_q  <= tgl_n;
    end
  end

  assign ctrl_byte = {mode_q, run_q, 2'b00, ie_q, pend_q};
  assign pin_out   = tgl_q;
  assign pend      = pend_q;
  assign irq       = pend_q & ie_q;

  assert_pend_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
    set_p |=> pend_q);

  assert_pend_keep_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !ctrl_we) |=> pend_q);

  assert_toggle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tog |=> (tgl_q != $past(tgl_q)));

  assert_toggle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !tog |=> $stable(tgl_q));

  assert_bad_mode_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MD_BAD_A || mode_q == MD_BAD_B) |-> (!dec && !cap));

endmodule

// File: rtl/mm_timer.sv
module mm_timer #(
  parameter int CW = 16,
  parameter int BW = 8,
  localparam int NB = CW / BW,
  localparam int AW = $clog2(2 * NB + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          pin_in,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [BW-1:0] bus_wdata,
  output logic [BW-1:0] bus_rdata,
  output logic          pin_out,
  output logic          pend,
  output logic          irq
);

  localparam logic [AW-1:0] CTRL_ADDR = AW'(2 * NB);

  logic          rise, fall;
  logic          dec, cap, reload_on_uf, uf;
  logic [NB-1:0] cnt_we, rld_we;
  logic          ctrl_we;
  logic [CW-1:0] count, rld;
  logic [7:0]    ctrl_byte;

  genvar gb;
  generate
    for (gb = 0; gb < NB; gb++) begin : g_dec
      assign cnt_we[gb] = bus_wr && (bus_addr == AW'(gb));
      assign rld_we[gb] = bus_wr && (bus_addr == AW'(NB + gb));
    end
  endgenerate
  assign ctrl_we = bus_wr && (bus_addr == CTRL_ADDR);

  tmr_sync_edge #(.STAGES(2)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (tick),
    .pin  (pin_in),
    .rise (rise),
    .fall (fall)
  );

  tmr_counter #(.CW(CW), .BW(BW)) u_cnt (
    .clk         (clk),
    .rst_n       (rst_n),
    .dec         (dec),
    .cap         (cap),
    .reload_on_uf(reload_on_uf),
    .cnt_we      (cnt_we),
    .rld_we      (rld_we),
    .wdata       (bus_wdata),
    .count       (count),
    .rld         (rld),
    .uf          (uf)
  );

  tmr_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick),
    .rise        (rise),
    .fall        (fall),
    .uf          (uf),
    .ctrl_we     (ctrl_we),
    .wdata       (bus_wdata[7:0]),
    .ctrl_byte   (ctrl_byte),
    .dec         (dec),
    .cap         (cap),
    .reload_on_uf(reload_on_uf),
    .pin_out     (pin_out),
    .pend        (pend),
    .irq         (irq)
  );

  always_comb begin
    bus_rdata = '0;
    for (int b = 0; b < NB; b++) begin
      if (bus_addr == AW'(b))      bus_rdata = count[b*BW +: BW];
      if (bus_addr == AW'(NB + b)) bus_rdata = rld[b*BW +: BW];
    end
    if (bus_addr == CTRL_ADDR) bus_rdata[7:0] = ctrl_byte;
  end

  // R2: a counter byte write lands in the next cycle regardless of counting
  assert_write_prio_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_we[0] |=> (count[BW-1:0] == $past(bus_wdata)));

endmodule

// File: tb/mm_timer_bench.sv
module mm_timer_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick;
  logic       pin_in;
  logic       bus_wr;
  logic [2:0] bus_addr;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic       pin_out, pend, irq;

  int n_chk = 0;
  int n_bad = 0;
  int tick_div = 1;
  int tick_ph = 0;
  bit done = 0;
  string cur_req = "R1";

  always #2 clk = ~clk;

  mm_timer u_mm_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick), .pin_in(pin_in),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .pin_out(pin_out), .pend(pend), .irq(irq)
  );

  // behavioural reference model
  int m_cnt, m_rld, m_mode;
  bit m_run, m_ie, m_pend, m_tgl;
  bit m_sync[$];
  bit m_smp;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_rld = 0; m_mode = 0;
      m_run = 0; m_ie = 0; m_pend = 0; m_tgl = 0;
      m_sync = '{0, 0}; m_smp = 0;
    end else begin
      bit lvl, r, f, ev, dn, cp, und;
      int nc, nr;
      lvl = m_sync[1];
      r = tick && lvl && !m_smp;
      f = tick && !lvl && m_smp;
      ev = (m_mode % 2 == 1) ? f : r;
      dn = m_run && ((m_mode < 2 && ev) || (m_mode >= 4 && tick));
      cp = m_run && m_mode >= 6 && ev;
      und = 0;
      nc = m_cnt;
      nr = m_rld;
      if (dn) begin
        if (m_cnt == 0) begin
          und = 1;
          nc = (m_mode >= 6) ? 65535 : m_rld;
        end else nc = m_cnt - 1;
      end
      if (cp) nr = m_cnt;
      if (und && m_mode == 5) m_tgl = !m_tgl;
      if (bus_wr) begin
        case (bus_addr)
          3'd0: nc = (nc & 'hFF00) | bus_wdata;
          3'd1: nc = (nc & 'h00FF) | (bus_wdata << 8);
          3'd2: nr = (nr & 'hFF00) | bus_wdata;
          3'd3: nr = (nr & 'h00FF) | (bus_wdata << 8);
          3'd4: begin
            m_mode = bus_wdata / 32;
            m_run  = bus_wdata[4];
            m_ie   = bus_wdata[1];
            if (!bus_wdata[0]) m_pend = 0;
          end
          default: ;
        endcase
      end
      if ((und && m_mode_old_ok(dn, cp, und)) || cp) m_pend = 1;
      m_cnt = nc;
      m_rld = nr;
      if (tick) m_smp = lvl;
      m_sync = '{pin_in, m_sync[0]};
    end
  end

  // underflow sets pending only outside the capture modes; uses the mode
  // latched before this cycle's write, held in prev_mode
  int prev_mode;
  always @(negedge clk) prev_mode = m_mode;
  function automatic bit m_mode_old_ok(bit dn, bit cp, bit und);
    return dn && und && prev_mode < 6;
  endfunction

  function automatic logic [7:0] exp_rd(logic [2:0] a);
    case (a)
      3'd0: return m_cnt[7:0];
      3'd1: return m_cnt[15:8];
      3'd2: return m_rld[7:0];
      3'd3: return m_rld[15:8];
      3'd4: return {m_mode[2:0], m_run, 2'b00, m_ie, m_pend};
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cmp_all();
    chk({cur_req, " rdata"}, bus_rdata, exp_rd(bus_addr));
    chk("R6 pin_out", pin_out, m_tgl);
    chk("R10 pend", pend, m_pend);
    chk("R10 irq", irq, m_pend && m_ie);
  endtask

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
      cmp_all();
      tick_ph++;
      tick = (tick_ph % tick_div == 0);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    cyc(1);
    bus_wr = 0;
  endtask

  task automatic rd(logic [2:0] a, string req, int exp);
    bus_addr = a;
    #1;
    chk(req, bus_rdata, exp);
  endtask

  task automatic pulses(int n, int w);
    for (int i = 0; i < n; i++) begin
      pin_in = 1; cyc(w);
      pin_in = 0; cyc(w);
    end
  endtask

  initial begin
    #600000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 0; tick = 0; pin_in = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    cur_req = "R1";
    for (int a = 0; a < 8; a++) rd(3'(a), "R1", 0);
    chk("R1 pin_out", pin_out, 0);
    chk("R1 pend", pend, 0);
    chk("R1 irq", irq, 0);

    // R2 byte access
    cur_req = "R2";
    wr(0, 8'h34); wr(1, 8'h12); wr(2, 8'h03); wr(3, 8'h00);
    rd(0, "R2", 8'h34); rd(1, "R2", 8'h12); rd(2, "R2", 8'h03); rd(3, "R2", 0);
    rd(5, "R2", 0);

    // R3 / R4 / R6 toggle timer, tick every cycle then every third
    cur_req = "R6";
    wr(0, 8'h02); wr(1, 8'h00);
    wr(4, 8'hB2);
    bus_addr = 0; cyc(20);
    cur_req = "R3";
    tick_div = 3;
    wr(4, 8'h92);
    bus_addr = 0; cyc(24);
    cur_req = "R4";
    wr(2, 8'h00); bus_addr = 0; cyc(9);
    tick_div = 1;

    // R11 clear versus set priority
    cur_req = "R11";
    wr(0, 8'h00); wr(1, 8'h00);
    wr(4, 8'h90);
    cyc(2);
    wr(4, 8'h90);
    chk("R11 set wins", pend, 1);
    wr(4, 8'h80);
    chk("R11 set wins", pend, 1);
    wr(4, 8'h80);
    chk("R11 cleared", pend, 0);
    wr(4, 8'h81);
    chk("R11 no set by 1", pend, 0);

    // R8 stopped counter holds
    cur_req = "R8";
    wr(0, 8'h50);
    pulses(2, 2);
    cyc(5);
    rd(0, "R8", 8'h50);

    // R7 capture on rising then falling edge, then wrap
    cur_req = "R7";
    wr(1, 8'h01); wr(0, 8'h00);
    wr(4, 8'hD2);
    cyc(6);
    pin_in = 1;
    cyc(8);
    n_chk++;
    bus_addr = 3; #1;
    if (bus_rdata != 0 || exp_rd(2) < 8'hF0) begin
      n_bad++;
      $display("FAIL R7: actual %0h%0h expected in F0..FF", bus_rdata, exp_rd(2));
    end
    wr(4, 8'hF0);
    cyc(4);
    pin_in = 0;
    cyc(8);
    wr(1, 8'h00); wr(0, 8'h01);
    cyc(3);
    rd(1, "R7 wrap", 8'hFF);
    wr(4, 8'h00);

    // R9 disallowed modes
    cur_req = "R9";
    wr(0, 8'h07); wr(1, 8'h00);
    wr(4, 8'h52);
    pulses(3, 2);
    wr(4, 8'h72);
    pulses(3, 2);
    rd(0, "R9", 8'h07);

    // R5 event counting on rising then falling edges
    cur_req = "R5";
    wr(4, 8'h00);
    cyc(4);
    wr(0, 8'h09); wr(2, 8'h09); wr(3, 8'h00);
    wr(4, 8'h12);
    pulses(3, 4);
    rd(0, "R5 rising", 6);
    wr(4, 8'h32);
    pulses(3, 4);
    rd(0, "R5 falling", 3);
    tick_div = 4;
    for (int i = 0; i < 16; i++) begin
      pin_in = ~pin_in; cyc(1);
    end
    pulses(4, 1);
    wr(4, 8'h12);
    pulses(6, 3);
    tick_div = 1;

    // R10 interrupt gating
    cur_req = "R10";
    wr(4, 8'h90);
    wr(0, 8'h00);
    cyc(2);
    chk("R10 no irq when disabled", irq, 0);
    wr(4, 8'h83);
    chk("R10 irq when enabled", irq, 1);
    cyc(4);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule